// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a single-port synchronous memory that runs reads and writes back to back, in any mix, with no idle cycle between them. Each access puts its address and control on one clock edge. The data for that access moves on the edge two enabled cycles later: write data is sampled from `din` on that edge, and read data is loaded into `dout` on that edge. A write is held in the pipeline until its data arrives, so the bus never has to turn around and no dead cycle is needed.

The word is made of byte lanes. Each lane holds eight data bits and one parity bit, and each lane has its own active-low write select. Three chip selects gate the start of new accesses. A clock enable freezes the whole pipeline. A 2-bit burst counter produces four beats from one loaded address, in linear or interleaved order. The data bus is split into an input port, an output port and a drive-enable flag. The array depth is set by a parameter.

Top module: `nodead_sram`

## Requirements
- R1: A read accepted on an enabled edge loads the addressed word into `dout` on the second enabled edge after it. A write accepted on an enabled edge takes its data from `din` on the second enabled edge after it.
- R2: While `clk_en_n` is high, every input is ignored and all internal state holds, including `dout`. The edge counts of R1 advance only on edges with `clk_en_n` low.
- R3: An access starts only on an edge where `ld_n` is low and the device is selected (`sel1_n`=0, `sel2`=1, `sel3_n`=0). If `ld_n` is low with the device not selected, no access starts, any running burst ends, and accesses already in the pipeline still complete.
- R4: `ld_n` low with the device selected loads `addr` as the burst base and starts beat 0. Each later enabled edge with `ld_n` high issues the next beat, with the same direction as the load. The 2-bit counter wraps after beat 3. With no burst running, `ld_n` high starts nothing.
- R5: Only the two low address bits step through a burst; the upper bits stay at the base. Beat k uses low bits (base+k) mod 4 when `burst_ilv` is 0, and base XOR k when `burst_ilv` is 1.
- R6: `wr_n`=0 on a load makes a write. Lane i is bits [9i+8:9i] of `din`, holding 8 data bits and 1 parity bit. On the data edge, lane i is stored only if `bw_n[i]` was 0 when the access was issued; lanes with `bw_n[i]`=1 keep their old contents.
- R7: `dout_en` is high only after a read's data edge, and only while `oe_n` is low. After the data edge of a write, or after the edge where a deselect or idle slot reaches the data phase, `dout_en` is low whatever `oe_n` is.
- R8: A read issued on the cycle right after a write to the same address returns the newly written lanes.
- R9: While `rst_n` is low, the pipeline and any burst are cleared and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls everything |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load a new address; high: advance the burst |
| wr_n | input | 1 | Low: write, high: read (sampled on load) |
| bw_n | input | LANES | Per-lane write select, active low |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output permit, active low |
| din | input | 9*LANES | Write data, sampled on the data edge |
| dout | output | 9*LANES | Registered read data |
| dout_en | output | 1 | High when `dout` should drive the bus |

## Verification
Every result is due on the second enabled edge after the access is issued. A stalled edge shifts that due time by one, so the bench's reference model moves its two-slot queue only on edges with the clock enable low. Inputs are driven on the falling edge. The model is stepped right after each rising edge, and both output ports are compared on the next falling edge, when the edge's register updates have settled. Lanes that have never been written are left out of the data comparison.

// File: rtl/nodead_sram.sv
module nodead_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en_n,
  input  logic                 sel1_n,
  input  logic                 sel2,
  input  logic                 sel3_n,
  input  logic                 ld_n,
  input  logic                 wr_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic [AW-1:0]        addr,
  input  logic                 burst_ilv,
  input  logic                 oe_n,
  input  logic [9*LANES-1:0]   din,
  output logic [9*LANES-1:0]   dout,
  output logic                 dout_en
);
  localparam int DW    = 9 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          bst_act, bst_wr;
  logic [AW-1:0] bst_base;
  logic [1:0]    bst_cnt;

  logic             s1_v, s1_wr, s2_v, s2_wr, drv;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_bw, s2_bw;

  wire       run    = !clk_en_n;
  wire       selok  = !sel1_n && sel2 && !sel3_n;
  wire [1:0] nxt    = bst_cnt + 2'd1;
  wire [1:0] lo     = burst_ilv ? (bst_base[1:0] ^ nxt) : (bst_base[1:0] + nxt);
  wire       load   = !ld_n && selok;
  wire       adv    = ld_n && bst_act;

  wire          iss_v  = load || adv;
  wire          iss_wr = load ? !wr_n : bst_wr;
  wire [AW-1:0] iss_a  = load ? addr : {bst_base[AW-1:2], lo};

  assign dout_en = drv && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_act  <= 1'b0;
      bst_wr   <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= '0;
      s1_v     <= 1'b0;
      s1_wr    <= 1'b0;
      s1_a     <= '0;
      s1_bw    <= '1;
      s2_v     <= 1'b0;
      s2_wr    <= 1'b0;
      s2_a     <= '0;
      s2_bw    <= '1;
      drv      <= 1'b0;
      dout     <= '0;
    end else if (run) begin
      if (!ld_n) begin
        bst_act  <= selok;
        bst_wr   <= !wr_n;
        bst_base <= addr;
        bst_cnt  <= 2'd0;
      end else if (bst_act) begin
        bst_cnt  <= nxt;
      end
      s1_v  <= iss_v;
      s1_wr <= iss_wr;
      s1_a  <= iss_a;
      s1_bw <= bw_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_bw <= s1_bw;
      drv   <= s2_v && !s2_wr;
      if (s2_v && !s2_wr) dout <= mem[s2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (run && s2_v && s2_wr) begin
      for (int i = 0; i < LANES; i++)
        if (!s2_bw[i]) mem[s2_a][9*i +: 9] <= din[9*i +: 9];
    end
  end
endmodule

module nodead_sram_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_en_n,
  input logic               sel1_n,
  input logic               sel2,
  input logic               sel3_n,
  input logic               ld_n,
  input logic               wr_n,
  input logic               oe_n,
  input logic [9*LANES-1:0] dout,
  input logic               dout_en
);
  wire selok = !sel1_n && sel2 && !sel3_n;

  // R9
  always @(posedge clk) if (!rst_n) reset_quiet_chk: assert (!dout_en);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(dout));

  // R1
  read_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && selok && wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> (dout_en || oe_n));

  // R7
  write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && selok && !wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> !dout_en);

  // R3
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !selok) ##1 !clk_en_n ##1 !clk_en_n |=> !dout_en);
endmodule

bind nodead_sram nodead_sram_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/nodead_sram_test.sv
`timescale 1ns/1ps
module nodead_sram_test;
  localparam int AW = 6, LANES = 4, DW = 9 * LANES, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic clk_en_n = 0, sel1_n = 0, sel2 = 1, sel3_n = 0, ld_n = 1, wr_n = 1;
  logic [LANES-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic burst_ilv = 0, oe_n = 0;
  logic [DW-1:0] din = '0, dout;
  logic dout_en;

  nodead_sram #(.AW(AW), .LANES(LANES)) uut (.*);

  always #2 clk = ~clk;

  typedef struct { bit v; bit wr; int a; bit [LANES-1:0] bw; } op_t;
  op_t pipe[$];
  bit [DW-1:0] rmem [DEPTH];
  bit [LANES-1:0] kn [DEPTH];
  bit b_on, b_wr; int b_base, b_k;
  bit e_drv; bit [DW-1:0] e_dout; bit [LANES-1:0] e_kn;
  int compared = 0, mismatched = 0;
  string tag = "R9";
  bit done = 0;

  function automatic bit [DW-1:0] lanemask(bit [LANES-1:0] m);
    bit [DW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) if (m[i]) r[9*i +: 9] = 9'h1ff;
    return r;
  endfunction

  task automatic model_reset();
    pipe.delete();
    pipe.push_back('{0, 0, 0, '1});
    pipe.push_back('{0, 0, 0, '1});
    b_on = 0; e_drv = 0; e_kn = '0;
  endtask

  task automatic model_step();
    op_t o, n;
    bit sel;
    if (clk_en_n) return;
    sel = (sel1_n == 0) && (sel2 == 1) && (sel3_n == 0);
    n = '{0, 0, 0, bw_n};
    if (!ld_n) begin
      b_on = sel; b_wr = !wr_n; b_base = addr; b_k = 0;
      if (sel) begin n.v = 1; n.wr = b_wr; n.a = addr; end
    end else if (b_on) begin
      int low;
      b_k = (b_k + 1) % 4;
      low = burst_ilv ? ((b_base % 4) ^ b_k) : (((b_base % 4) + b_k) % 4);
      n.v = 1; n.wr = b_wr; n.a = (b_base / 4) * 4 + low;
    end
    o = pipe.pop_front();
    pipe.push_back(n);
    if (o.v && o.wr) begin
      for (int i = 0; i < LANES; i++)
        if (!o.bw[i]) begin rmem[o.a][9*i +: 9] = din[9*i +: 9]; kn[o.a][i] = 1; end
      e_drv = 0;
    end else if (o.v) begin
      e_drv = 1; e_dout = rmem[o.a]; e_kn = kn[o.a];
    end else e_drv = 0;
  endtask

  task automatic compare();
    bit exp_en = e_drv && !oe_n;
    bit [DW-1:0] m = lanemask(e_kn);
    compared++;
    if (dout_en !== exp_en) begin
      mismatched++;
      $display("FAIL %s dout_en actual %0b expected %0b at %0t", tag, dout_en, exp_en, $time);
    end else if (e_drv && ((dout & m) !== (e_dout & m))) begin
      mismatched++;
      $display("FAIL %s dout actual %h expected %h at %0t", tag, dout & m, e_dout & m, $time);
    end
  endtask

  task automatic cyc(bit ce, bit l, bit w, int a, bit [LANES-1:0] b, bit [2:0] s, bit o);
    clk_en_n = ce; ld_n = l; wr_n = w; addr = a[AW-1:0]; bw_n = b;
    {sel1_n, sel2, sel3_n} = s; oe_n = o;
    din = {$urandom, $urandom};
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  localparam bit [2:0] SON = 3'b010;
  task automatic wr1(int a, bit [LANES-1:0] b = '0); cyc(0, 0, 0, a, b, SON, 0); endtask
  task automatic rd1(int a); cyc(0, 0, 1, a, '1, SON, 0); endtask
  task automatic adv(); cyc(0, 1, 1, 0, '1, SON, 0); endtask
  task automatic advw(); cyc(0, 1, 0, 0, '0, SON, 0); endtask
  task automatic idle(); cyc(0, 0, 1, 0, '1, 3'b110, 0); endtask

  initial begin
    int ws;
    ws = 0;
    while (!done && ws < 150000) begin @(posedge clk); ws++; end
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    for (int i = 0; i < DEPTH; i++) kn[i] = '0;
    repeat (3) @(negedge clk);
    tag = "R9"; compare();
    rst_n = 1;
    idle(); idle();
    // R1: single writes, then single reads
    tag = "R1";
    for (int i = 0; i < 8; i++) wr1(i);
    for (int i = 0; i < 8; i++) rd1(i);
    idle(); idle();
    // R8: alternate write/read on same address with no gap
    tag = "R8";
    for (int i = 8; i < 14; i++) begin wr1(i); rd1(i); end
    idle(); idle();
    // R6: partial lane writes then read back
    tag = "R6";
    wr1(2, 4'b0101); wr1(3, 4'b1110); wr1(4, 4'b1111); rd1(2); rd1(3); rd1(4);
    idle(); idle();
    // R4/R5: linear write burst from base with low bits 01
    tag = "R5";
    burst_ilv = 0;
    wr1(21); advw(); advw(); advw();
    idle(); idle();
    for (int i = 20; i < 24; i++) rd1(i);
    // R4: interleaved read burst from low bits 10, wrapping past beat 3
    tag = "R4";
    burst_ilv = 1;
    rd1(22); adv(); adv(); adv(); adv(); adv();
    idle(); idle();
    burst_ilv = 0;
    rd1(5); adv(); adv(); adv();
    idle(); idle();
    // R2: stalls inside a mixed stream
    tag = "R2";
    wr1(30); cyc(1, 0, 1, 31, '0, SON, 0); cyc(1, 1, 0, 9, '0, 3'b110, 1);
    rd1(30); cyc(1, 0, 0, 30, '0, SON, 0); rd1(1); cyc(1, 1, 1, 0, '1, SON, 0);
    cyc(1, 1, 1, 0, '1, SON, 0); idle(); idle(); idle();
    // R3: each select deasserted stops a burst; pipeline still drains
    tag = "R3";
    rd1(0); cyc(0, 0, 1, 1, '1, 3'b110, 0); adv(); adv();
    rd1(1); cyc(0, 0, 1, 1, '1, 3'b000, 0); adv();
    rd1(2); cyc(0, 0, 0, 2, '0, 3'b011, 0); advw(); rd1(2);
    idle(); idle();
    // R7: output permit low/high and write data phases
    tag = "R7";
    rd1(3); cyc(0, 0, 1, 4, '1, SON, 1); cyc(0, 0, 0, 5, '0, SON, 1); cyc(0, 0, 1, 3, '1, SON, 0);
    idle(); idle();
    // random mix
    tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      bit ce = ($urandom % 10) == 0;
      bit l  = ($urandom % 10) < 6;
      bit [2:0] s = (($urandom % 10) == 0) ? 3'($urandom) : SON;
      burst_ilv = (n / 500) % 2;
      cyc(ce, l, $urandom % 2, $urandom % DEPTH, LANES'($urandom), s, ($urandom % 10) == 0);
    end
    // R9: reset mid-stream
    tag = "R9";
    rd1(0); rd1(1);
    rst_n = 0; model_reset();
    @(negedge clk); compare();
    rst_n = 1;
    adv(); adv(); adv();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule